// File: doc/BRIEF.md
# Pilot Tone Identification Classifier

This block decides whether a two-carrier television sound broadcast is mono, stereo or bilingual. It receives the squared-up identification tone after the upstream band-pass filter, AM detector and comparator, and measures the tone period against a free-running reference clock. The measured period is tested against one frequency window per tone class. Each class has a narrow window for acquiring it and a wider window for keeping it, so the decision has hysteresis.

A time filter sits between the window test and the outputs. It is slow to switch on and fast to switch off, so the indicator does not blink on a weak or noisy tone. A class is reported only after its tone has qualified without a break for a long dwell. A reported class falls back to mono after a shorter spell of lost qualification. Both a stereo and a bilingual indicator are active low. A 2-bit status code carries the same decision for a host interface.

With the default parameters the reference clock runs at 16 kHz. In that case the window limits correspond to the nominal 150 Hz and 276 Hz tones, and the dwell times correspond to 1 s on and 0.3 s off.

Top module: `tone_id_classifier`

## Requirements
- R1: After reset the status code is 00 (mono), both indicator outputs are high and no dwell is in progress.
- R2: The measured period is the number of reference cycles between two successive rising edges of the tone. From mono, only periods of ST_ACQ_LO..ST_ACQ_HI counts inclusive (default 100..114) qualify for stereo, which is status code 01.
- R3: While stereo is reported, every period of ST_REL_LO..ST_REL_HI counts inclusive (default 91..128) keeps it qualified. A period in that range but outside the acquire range never starts stereo from mono.
- R4: From mono, only periods of BI_ACQ_LO..BI_ACQ_HI counts inclusive (default 54..62) qualify for bilingual, which is status code 10.
- R5: While bilingual is reported, every period of BI_REL_LO..BI_REL_HI counts inclusive (default 52..67) keeps it qualified. A period outside that range starts its loss.
- R6: A class is reported exactly ON_CYCLES reference cycles after its first qualifying measurement, so never sooner than ON_CYCLES after the tone starts. Any non-qualifying measurement or timeout before then restarts the dwell.
- R7: A reported class returns to mono exactly OFF_CYCLES cycles after the first non-qualifying measurement or timeout. A loss that ends, through a qualifying measurement, before OFF_CYCLES elapse leaves the class reported.
- R8: If no rising edge arrives within TIMEOUT counts (default 140) of the previous one, this counts as an out-of-window measurement. The first edge after a timeout only restarts the measurement, so a tone slower than TIMEOUT never qualifies.
- R9: Stereo and bilingual are never reported together. A change between them always passes through mono (code 00).
- R10: The stereo indicator is low exactly when the code is 01, and the bilingual indicator is low exactly when the code is 10. Code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tone_in | input | 1 | Squared identification tone, asynchronous to clk |
| st_ind_n | output | 1 | Stereo indicator enable, low while stereo is reported |
| bi_ind_n | output | 1 | Bilingual indicator enable, low while bilingual is reported |
| status_code | output | 2 | 00 mono, 01 stereo, 10 bilingual |

## Verification
A wrong dwell count or a mis-held qualification state shows at the ports only as a class transition at the wrong time. The bench therefore brackets every transition. It samples once just before the earliest time a correct design may change and once just after the latest time it must have changed, the latter being one dwell plus a few tone periods. Window limit errors are caught by directed periods one count on each side of every limit, in both the acquiring and the holding direction. A stale timeout or arming state appears as an acquisition or a release that happens too early.

// File: rtl/tid_pkg.sv
// Shared types for the pilot tone identification classifier.
package tid_pkg;
    typedef enum logic [1:0] {
        CLS_MONO   = 2'b00,
        CLS_STEREO = 2'b01,
        CLS_BILING = 2'b10
    } tid_class_e;
endpackage

// File: rtl/tid_period_meter.sv
// Measures the period of an asynchronous tone between rising edges.
// Assumes tone_in is a clean square wave; it is resynchronised here.
// A missing edge for TIMEOUT cycles raises meas_timeout and disarms,
// so the next edge only restarts the measurement.
module tid_period_meter #(
    parameter int TIMEOUT = 140,
    localparam int PW = $clog2(TIMEOUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tone_in,
    output logic          meas_valid,
    output logic          meas_timeout,
    output logic [PW-1:0] meas_period
);
    logic [2:0]    sync_q;
    logic          rise;
    logic          armed_q;
    logic [PW-1:0] cnt_q;

    // Two-stage synchroniser plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 3'b000;
        else        sync_q <= {sync_q[1:0], tone_in};
    end

    assign rise = sync_q[1] & ~sync_q[2];

    // Period counter with timeout and arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            armed_q      <= 1'b0;
            meas_valid   <= 1'b0;
            meas_timeout <= 1'b0;
            meas_period  <= '0;
        end else begin
            meas_valid   <= 1'b0;
            meas_timeout <= 1'b0;
            if (rise) begin
                if (armed_q) begin
                    meas_valid  <= 1'b1;
                    meas_period <= cnt_q + 1'b1;
                end
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end else if (cnt_q == PW'(TIMEOUT - 1)) begin
                meas_timeout <= 1'b1;
                armed_q      <= 1'b0;
                cnt_q        <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tid_range.sv
// Inclusive window test of a period against constant limits.
module tid_range #(
    parameter int PW = 8,
    parameter int LO = 0,
    parameter int HI = 255
) (
    input  logic [PW-1:0] period,
    output logic          hit
);
    // Window comparison.
    always_comb hit = (period >= PW'(LO)) && (period <= PW'(HI));
endmodule

// File: rtl/tid_debounce.sv
// Hysteretic class decision with slow-on / fast-off dwell filtering.
// hits[0]/[1]: stereo acquire/hold windows; hits[2]/[3]: bilingual
// acquire/hold windows, all valid only with meas_valid.
// The match register holds the latest qualification verdict.
module tid_debounce
    import tid_pkg::*;
#(
    parameter int ON_CYCLES  = 16000,
    parameter int OFF_CYCLES = 4800,
    localparam int DMAX = (ON_CYCLES > OFF_CYCLES) ? ON_CYCLES : OFF_CYCLES,
    localparam int DW   = $clog2(DMAX + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       meas_valid,
    input  logic       meas_timeout,
    input  logic [3:0] hits,
    output tid_class_e cls
);
    tid_class_e    match_q, eval, upd;
    logic [DW-1:0] dwell_q;

    // Verdict of a fresh measurement, judged against the reported class.
    always_comb begin
        unique case (cls)
            CLS_STEREO: eval = hits[1] ? CLS_STEREO : CLS_MONO;
            CLS_BILING: eval = hits[3] ? CLS_BILING : CLS_MONO;
            default:    eval = hits[0] ? CLS_STEREO :
                               (hits[2] ? CLS_BILING : CLS_MONO);
        endcase
    end

    // Next verdict: timeout disqualifies, a sample re-evaluates.
    always_comb begin
        if (meas_timeout)    upd = CLS_MONO;
        else if (meas_valid) upd = eval;
        else                 upd = match_q;
    end

    // Dwell counter and reported class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls     <= CLS_MONO;
            match_q <= CLS_MONO;
            dwell_q <= '0;
        end else begin
            match_q <= upd;
            if (upd != match_q) begin
                dwell_q <= '0;
            end else if (cls == CLS_MONO && match_q != CLS_MONO) begin
                if (dwell_q == DW'(ON_CYCLES - 1)) begin
                    cls     <= match_q;
                    dwell_q <= '0;
                end else begin
                    dwell_q <= dwell_q + 1'b1;
                end
            end else if (cls != CLS_MONO && match_q == CLS_MONO) begin
                if (dwell_q == DW'(OFF_CYCLES - 1)) begin
                    cls     <= CLS_MONO;
                    dwell_q <= '0;
                end else begin
                    dwell_q <= dwell_q + 1'b1;
                end
            end else begin
                dwell_q <= '0;
            end
        end
    end
endmodule

// File: rtl/tone_id_classifier.sv
// Top level: period meter, four window tests and the dwell filter.
// Assumes a free-running reference clock; all limits are in its cycles.
module tone_id_classifier
    import tid_pkg::*;
#(
    parameter int TIMEOUT    = 140,
    parameter int ST_ACQ_LO  = 100,
    parameter int ST_ACQ_HI  = 114,
    parameter int ST_REL_LO  = 91,
    parameter int ST_REL_HI  = 128,
    parameter int BI_ACQ_LO  = 54,
    parameter int BI_ACQ_HI  = 62,
    parameter int BI_REL_LO  = 52,
    parameter int BI_REL_HI  = 67,
    parameter int ON_CYCLES  = 16000,
    parameter int OFF_CYCLES = 4800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tone_in,
    output logic       st_ind_n,
    output logic       bi_ind_n,
    output logic [1:0] status_code
);
    localparam int PW = $clog2(TIMEOUT + 1);
    localparam int WIN_LO [4] = '{ST_ACQ_LO, ST_REL_LO, BI_ACQ_LO, BI_REL_LO};
    localparam int WIN_HI [4] = '{ST_ACQ_HI, ST_REL_HI, BI_ACQ_HI, BI_REL_HI};

    logic          meas_valid, meas_timeout;
    logic [PW-1:0] meas_period;
    logic [3:0]    raw_hit, hits;
    tid_class_e    cls;

    tid_period_meter #(.TIMEOUT(TIMEOUT)) u_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tone_in     (tone_in),
        .meas_valid  (meas_valid),
        .meas_timeout(meas_timeout),
        .meas_period (meas_period)
    );

    for (genvar i = 0; i < 4; i++) begin : g_win
        tid_range #(.PW(PW), .LO(WIN_LO[i]), .HI(WIN_HI[i])) u_rng (
            .period(meas_period),
            .hit   (raw_hit[i])
        );
    end

    // Window hits count only alongside a fresh measurement.
    always_comb hits = raw_hit & {4{meas_valid}};

    tid_debounce #(.ON_CYCLES(ON_CYCLES), .OFF_CYCLES(OFF_CYCLES)) u_deb (
        .clk         (clk),
        .rst_n       (rst_n),
        .meas_valid  (meas_valid),
        .meas_timeout(meas_timeout),
        .hits        (hits),
        .cls         (cls)
    );

    // Output decode.
    always_comb begin
        status_code = cls;
        st_ind_n    = (cls != CLS_STEREO);
        bi_ind_n    = (cls != CLS_BILING);
    end
endmodule

// File: rtl/tid_checker.sv
// Port-level properties of the classifier, bound to the top module.
module tid_checker #(
    parameter int ON_CYCLES = 16000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       st_ind_n,
    input logic       bi_ind_n,
    input logic [1:0] status_code
);
    logic [31:0] mono_run;

    // Cycles spent reporting mono, saturating at ON_CYCLES.
    always_ff @(posedge clk) begin
        if (!rst_n)                       mono_run <= '0;
        else if (status_code != 2'b00)    mono_run <= '0;
        else if (mono_run < ON_CYCLES)    mono_run <= mono_run + 1;
    end

    assert_reset_mono_R1: assert property (@(posedge clk)
        !rst_n |=> (status_code == 2'b00 && st_ind_n && bi_ind_n));

    assert_slow_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_code) == 2'b00 && status_code != 2'b00)
        |-> (mono_run >= ON_CYCLES - 1));

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!st_ind_n && !bi_ind_n));

    assert_via_mono_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_code) != 2'b00)
        |-> (status_code == $past(status_code) || status_code == 2'b00));

    assert_code_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status_code != 2'b11);

    assert_ind_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_ind_n == (status_code == 2'b01)) && (!bi_ind_n == (status_code == 2'b10)));
endmodule

bind tone_id_classifier tid_checker #(.ON_CYCLES(ON_CYCLES)) u_tid_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_ind_n   (st_ind_n),
    .bi_ind_n   (bi_ind_n),
    .status_code(status_code)
);

// File: tb/tone_id_classifier_test.sv
module tone_id_classifier_test;
    localparam int CLK_PERIOD = 10;
    localparam int ON  = 2000;
    localparam int OFF = 600;
    localparam int TMO = 140;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tone = 1'b0;
    logic       st_n, bi_n;
    logic [1:0] code;
    int         tone_p = 0;
    int         n_chk = 0;
    int         n_fail = 0;
    int         excl_err = 0;
    bit         done = 1'b0;

    tone_id_classifier #(.ON_CYCLES(ON), .OFF_CYCLES(OFF), .TIMEOUT(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .tone_in(tone),
        .st_ind_n(st_n), .bi_ind_n(bi_n), .status_code(code)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Expected class from mono for a steady period (R2, R4, R8).
    function automatic logic [1:0] acq_class(int p);
        if (p >= 100 && p <= 114) return 2'b01;
        if (p >= 54 && p <= 62)   return 2'b10;
        return 2'b00;
    endfunction

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare code and both indicators against the expected class (R10).
    task automatic chk(string req, logic [1:0] exp);
        logic es, eb;
        es = (exp != 2'b01);
        eb = (exp != 2'b10);
        n_chk++;
        if (code !== exp || st_n !== es || bi_n !== eb) begin
            n_fail++;
            $display("FAIL %s: code=%b st_n=%b bi_n=%b expected code=%b st_n=%b bi_n=%b",
                     req, code, st_n, bi_n, exp, es, eb);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Tone generator: period tone_p cycles, silent when zero.
    initial begin
        forever begin : gen
            int p;
            p = tone_p;
            if (p == 0) begin
                tone = 1'b0;
                @(negedge clk);
            end else begin
                tone = 1'b1;
                repeat (p / 2) @(negedge clk);
                tone = 1'b0;
                repeat (p - p / 2) @(negedge clk);
            end
        end
    end

    // Exclusivity monitor (R9).
    always @(negedge clk) if (rst_n && !st_n && !bi_n) excl_err++;

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            report();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        wait_cyc(5);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset", 2'b00);

        // Stereo acquisition with slow-on timing.
        tone_p = 107; wait_cyc(ON - 20);  chk("R6 not before dwell", 2'b00);
        wait_cyc(2 * 107 + 40);           chk("R2 stereo acquired", 2'b01);
        // Hold window keeps stereo.
        tone_p = 122; wait_cyc(OFF + 600); chk("R3 hold at 122", 2'b01);
        tone_p = 128; wait_cyc(OFF + 600); chk("R3 hold at 128", 2'b01);
        // Leaving hold window: fast-off timing.
        tone_p = 129; wait_cyc(OFF - 10);  chk("R7 still held", 2'b01);
        wait_cyc(3 * 129 + 40);            chk("R7 released at 129", 2'b00);
        // Hold-only period never acquires.
        tone_p = 122; wait_cyc(ON + 600);  chk("R3 no acquire at 122", 2'b00);
        // Acquire boundary.
        tone_p = 0;  wait_cyc(300);
        tone_p = 99; wait_cyc(ON + 600);   chk("R2 no acquire at 99", 2'b00);
        tone_p = 100; wait_cyc(ON + 3 * 100 + 40); chk("R2 acquire at 100", 2'b01);
        // Direct jump to bilingual tone passes through mono.
        tone_p = 58; wait_cyc(OFF - 10);   chk("R9 stereo before loss", 2'b01);
        wait_cyc(310);                     chk("R9 mono in between", 2'b00);
        wait_cyc(ON + 100);                chk("R4 bilingual acquired", 2'b10);
        // Bilingual hold window.
        tone_p = 65; wait_cyc(OFF + 600);  chk("R5 hold at 65", 2'b10);
        tone_p = 52; wait_cyc(OFF + 600);  chk("R5 hold at 52", 2'b10);
        tone_p = 51; wait_cyc(OFF + 3 * 52 + 40); chk("R5 released at 51", 2'b00);
        tone_p = 58; wait_cyc(ON + 3 * 58 + 40);  chk("R4 reacquire at 58", 2'b10);
        // Short dropout shorter than the release dwell is ignored.
        tone_p = 0;  wait_cyc(300);
        tone_p = 58; wait_cyc(OFF + 600);  chk("R7 dropout ignored", 2'b10);
        // Silence: timeout-driven release.
        tone_p = 0;  wait_cyc(OFF - 10);   chk("R7 held during silence", 2'b10);
        wait_cyc(TMO + 60);                chk("R8 timeout release", 2'b00);
        tone_p = 145; wait_cyc(ON + 600);  chk("R8 slow tone ignored", 2'b00);
        // Interrupted qualification restarts the on-dwell.
        tone_p = 0;   wait_cyc(200);
        tone_p = 107; wait_cyc(1000);
        tone_p = 0;   wait_cyc(300);
        tone_p = 107; wait_cyc(ON - 20);   chk("R6 dwell restarted", 2'b00);
        wait_cyc(2 * 107 + 40);            chk("R6 acquire after restart", 2'b01);
        tone_p = 0;   wait_cyc(OFF + TMO + 60); chk("R7 silence release", 2'b00);

        // Random steady periods from mono.
        for (int i = 0; i < 12; i++) begin
            int p;
            p = 40 + int'($urandom_range(110));
            tone_p = p;
            wait_cyc(ON + 2 * p + 40);
            chk($sformatf("R2/R4/R8 random period %0d (R2 R4 R8)", p), acq_class(p));
            tone_p = 0;
            wait_cyc(OFF + TMO + 60);
            chk("R7 random release", 2'b00);
        end

        n_chk++;
        if (excl_err != 0) begin
            n_fail++;
            $display("FAIL R9 both indicators low: %0d cycles, expected 0", excl_err);
        end
        done = 1'b1;
        report();
    end
endmodule